// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store of whole cache lines that sits beside a direct-mapped data cache. It only holds lines that the direct-mapped array has thrown out. When the main cache misses, it presents the missing line address on the lookup stream. The buffer compares that address against every stored entry at once. Each entry has its own full line-address tag and its own comparator.

On a buffer hit, the matching line goes back to the main cache on the swap-out stream. In the same operation, the line that the main cache displaces at that index takes over the freed slot. If the main cache had no valid line there, the slot is emptied instead. On a buffer miss, a request for the line goes to the next lower level. When that refill later displaces a line from the main cache, the discarded line arrives on the evict-insert stream and is stored. An empty slot is used if one exists; otherwise the oldest inserted entry is overwritten.

All data-carrying interfaces are valid/ready streams:
- A transfer happens on a clock edge where valid and ready are both high.
- An output stream (swap-out, next-level request) that has valid high keeps valid and its payload unchanged until ready is seen.
- The evict-insert stream is always ready.
- The lookup stream is ready only when no swap-out or next-level request is pending and no insert is offered in the same cycle. As a result, an insert always wins over a lookup.

Top module: `vcb_victim_buf`

## Requirements
- R1: After reset every entry is empty, so a lookup of any address reports a miss.
- R2: A lookup accepted on clock edge T makes `res_valid` high for exactly the cycle after T. In that cycle `res_hit` and, on a hit, `res_idx` (the slot number, 0 to N-1) are valid.
- R3: A lookup hits exactly when some valid entry's stored tag equals the full line address `lk_addr`. `res_idx` names that entry.
- R4: On a hit, the swap-out stream carries the hit entry's address and data. If `lk_disp_valid` is 1, the displaced line (`lk_disp_addr`, `lk_disp_data`) occupies the same slot and counts as the newest insertion. If `lk_disp_valid` is 0, that slot becomes empty.
- R5: On a miss, the next-level stream carries `nl_addr` equal to the looked-up address, and the stored lines are unchanged.
- R6: An insert stores its line. If any slot is empty, the lowest-numbered empty slot is used.
- R7: An insert into a full buffer overwrites the entry whose most recent insertion (including swap-ins) is oldest.
- R8: `so_valid`/`nl_valid` and their payloads stay constant until the matching ready is high. `lk_ready` is low while either is pending.
- R9: `ev_ready` is always 1. When `ev_valid` and `lk_valid` are offered together, `lk_ready` is low and the insert completes first.
- R10: The swap-out and next-level streams are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup offered (main cache missed) |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | AW | Missing line address |
| lk_disp_valid | input | 1 | Main cache holds a valid line at the missing index |
| lk_disp_addr | input | AW | Line address of the displaced main-cache line |
| lk_disp_data | input | DW | Data of the displaced main-cache line |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Lookup found the line in the buffer |
| res_idx | output | IW | Slot that hit |
| ev_valid | input | 1 | Discarded line offered for insertion |
| ev_ready | output | 1 | Insert accepted (constant 1) |
| ev_addr | input | AW | Line address of the discarded line |
| ev_data | input | DW | Data of the discarded line |
| so_valid | output | 1 | Hit line offered to the main cache |
| so_ready | input | 1 | Main cache takes the hit line |
| so_addr | output | AW | Line address of the hit line |
| so_data | output | DW | Data of the hit line |
| nl_valid | output | 1 | Request to next lower level pending |
| nl_ready | input | 1 | Next level takes the request |
| nl_addr | output | AW | Requested line address |

## Verification
The assertions watch, on every cycle, the rules that involve only the streams:
- the result strobe follows each accepted lookup by exactly one cycle;
- a hit always brings up swap-out and a miss always brings up a next-level request with the looked-up address;
- pending output payloads stay frozen under back-pressure;
- the two output streams are never valid together.

Only the bench scenarios can show what is stored and where:
- which slot an insert picks;
- that a swap leaves the displaced line findable in the hit slot, or empties that slot;
- that full-buffer inserts remove the oldest insertion.

The bench checks these with address sweeps against an ordered-list model.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_INSERT    = 2'd1,
    OP_SWAP_KEEP = 2'd2,
    OP_SWAP_DROP = 2'd3
  } vcb_op_e;
endpackage

// File: rtl/vcb_match.sv
module vcb_match #(
  parameter int N  = 4,
  parameter int AW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        key,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  logic [N-1:0] eq;

  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tags[g] == key);
  end

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/vcb_order.sv
module vcb_order
  import vcb_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vcb_op_e       op,
  input  logic [IW-1:0] op_slot,
  output logic [N-1:0]  vld,
  output logic [IW-1:0] ins_slot
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  // rank 0 = most recently inserted valid entry
  logic [N-1:0]  vld_q, vld_d;
  logic [IW-1:0] rank_q [N];
  logic [IW-1:0] rank_d [N];
  logic          full;

  assign full = &vld_q;
  assign vld  = vld_q;

  always_comb begin
    ins_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_q[i] == OLDEST) ins_slot = IW'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) ins_slot = IW'(i);
    end
  end

  always_comb begin
    vld_d = vld_q;
    for (int j = 0; j < N; j++) rank_d[j] = rank_q[j];
    unique case (op)
      OP_INSERT: begin
        for (int j = 0; j < N; j++) begin
          if (IW'(j) != ins_slot && vld_q[j] &&
              (!full || rank_q[j] < rank_q[ins_slot]))
            rank_d[j] = rank_q[j] + 1'b1;
        end
        vld_d[ins_slot]  = 1'b1;
        rank_d[ins_slot] = '0;
      end
      OP_SWAP_KEEP: begin
        for (int j = 0; j < N; j++) begin
          if (IW'(j) != op_slot && vld_q[j] && rank_q[j] < rank_q[op_slot])
            rank_d[j] = rank_q[j] + 1'b1;
        end
        rank_d[op_slot] = '0;
      end
      OP_SWAP_DROP: begin
        for (int j = 0; j < N; j++) begin
          if (IW'(j) != op_slot && vld_q[j] && rank_q[j] > rank_q[op_slot])
            rank_d[j] = rank_q[j] - 1'b1;
        end
        vld_d[op_slot]  = 1'b0;
        rank_d[op_slot] = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int j = 0; j < N; j++) rank_q[j] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int j = 0; j < N; j++) rank_q[j] <= rank_d[j];
    end
  end
endmodule

// File: rtl/vcb_lines.sv
module vcb_lines #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IW-1:0]        wslot,
  input  logic [AW-1:0]        waddr,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][AW-1:0] tags,
  output logic [N-1:0][DW-1:0] lines
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && wslot == IW'(g)) begin
        tags[g]  <= waddr;
        lines[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/vcb_victim_buf.sv
module vcb_victim_buf
  import vcb_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  output logic          lk_ready,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_disp_valid,
  input  logic [AW-1:0] lk_disp_addr,
  input  logic [DW-1:0] lk_disp_data,
  output logic          res_valid,
  output logic          res_hit,
  output logic [IW-1:0] res_idx,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  output logic          so_valid,
  input  logic          so_ready,
  output logic [AW-1:0] so_addr,
  output logic [DW-1:0] so_data,
  output logic          nl_valid,
  input  logic          nl_ready,
  output logic [AW-1:0] nl_addr
);
  logic [N-1:0]         vld;
  logic [N-1:0][AW-1:0] tags;
  logic [N-1:0][DW-1:0] lines;
  logic                 m_hit;
  logic [IW-1:0]        m_idx, ins_slot, wslot;
  logic                 lk_fire, we;
  logic [AW-1:0]        waddr;
  logic [DW-1:0]        wdata;
  vcb_op_e              op;

  assign ev_ready = 1'b1;
  assign lk_ready = !so_valid && !nl_valid && !ev_valid;
  assign lk_fire  = lk_valid && lk_ready;

  vcb_match #(.N(N), .AW(AW)) u_match (
    .vld(vld), .tags(tags), .key(lk_addr), .hit(m_hit), .idx(m_idx)
  );

  always_comb begin
    op    = OP_NONE;
    we    = 1'b0;
    wslot = ins_slot;
    waddr = ev_addr;
    wdata = ev_data;
    if (ev_valid) begin
      op = OP_INSERT;
      we = 1'b1;
    end else if (lk_fire && m_hit) begin
      wslot = m_idx;
      waddr = lk_disp_addr;
      wdata = lk_disp_data;
      op    = lk_disp_valid ? OP_SWAP_KEEP : OP_SWAP_DROP;
      we    = lk_disp_valid;
    end
  end

  vcb_order #(.N(N)) u_order (
    .clk(clk), .rst_n(rst_n), .op(op), .op_slot(m_idx),
    .vld(vld), .ins_slot(ins_slot)
  );

  vcb_lines #(.N(N), .AW(AW), .DW(DW)) u_lines (
    .clk(clk), .we(we), .wslot(wslot), .waddr(waddr), .wdata(wdata),
    .tags(tags), .lines(lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      so_valid  <= 1'b0;
      so_addr   <= '0;
      so_data   <= '0;
      nl_valid  <= 1'b0;
      nl_addr   <= '0;
    end else begin
      res_valid <= lk_fire;
      res_hit   <= lk_fire && m_hit;
      if (lk_fire) res_idx <= m_idx;
      if (lk_fire && m_hit) begin
        so_valid <= 1'b1;
        so_addr  <= tags[m_idx];
        so_data  <= lines[m_idx];
      end else if (so_ready) begin
        so_valid <= 1'b0;
      end
      if (lk_fire && !m_hit) begin
        nl_valid <= 1'b1;
        nl_addr  <= lk_addr;
      end else if (nl_ready) begin
        nl_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcb_victim_buf_chk.sv
module vcb_victim_buf_chk #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_ready,
  input logic [AW-1:0] lk_addr,
  input logic          lk_disp_valid,
  input logic [AW-1:0] lk_disp_addr,
  input logic [DW-1:0] lk_disp_data,
  input logic          res_valid,
  input logic          res_hit,
  input logic [IW-1:0] res_idx,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [AW-1:0] ev_addr,
  input logic [DW-1:0] ev_data,
  input logic          so_valid,
  input logic          so_ready,
  input logic [AW-1:0] so_addr,
  input logic [DW-1:0] so_data,
  input logic          nl_valid,
  input logic          nl_ready,
  input logic [AW-1:0] nl_addr
);
  assert_res_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  assert_res_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid && lk_ready));

  assert_hit_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (so_valid && !nl_valid));

  assert_miss_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (nl_valid && nl_addr == $past(lk_addr)));

  assert_so_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (so_valid && !so_ready) |=> (so_valid && $stable(so_addr) && $stable(so_data)));

  assert_nl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_valid && !nl_ready) |=> (nl_valid && $stable(nl_addr)));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(so_valid && nl_valid));
endmodule

bind vcb_victim_buf vcb_victim_buf_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/vcb_victim_buf_tb.sv
module vcb_victim_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int SPACE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_disp_valid = 0;
  logic [AW-1:0] lk_addr = '0, lk_disp_addr = '0, ev_addr = '0;
  logic [DW-1:0] lk_disp_data = '0, ev_data = '0;
  logic ev_valid = 0, so_ready = 0, nl_ready = 0;
  logic lk_ready, res_valid, res_hit, ev_ready, so_valid, nl_valid;
  logic [IW-1:0] res_idx;
  logic [AW-1:0] so_addr, nl_addr;
  logic [DW-1:0] so_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcb_victim_buf #(.N(N), .AW(AW), .DW(DW)) u_dut (.*);

  int total = 0, bad = 0;
  // model: slot contents plus insertion order, newest first
  bit            mv [N];
  logic [AW-1:0] ma [N];
  logic [DW-1:0] md [N];
  int            ord [N];
  int            cnt = 0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int mfind(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] fresh(input int seed);
    int a = seed % SPACE;
    while (mfind(AW'(a)) >= 0) a = (a + 1) % SPACE;
    return AW'(a);
  endfunction

  task automatic mremove(input int s);
    int p = 0;
    for (int i = 0; i < cnt; i++) if (ord[i] == s) p = i;
    for (int q = p; q < cnt - 1; q++) ord[q] = ord[q+1];
    cnt--;
  endtask

  task automatic mpush(input int s);
    for (int q = cnt; q > 0; q--) ord[q] = ord[q-1];
    ord[0] = s;
    cnt++;
  endtask

  // expected slot of the next insert: lowest empty, else oldest
  function automatic int mins_slot();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return ord[N-1];
  endfunction

  task automatic do_insert(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int s = mins_slot();
    @(negedge clk);
    ev_valid = 1; ev_addr = a; ev_data = d;
    chk(ev_ready == 1'b1, "R9 ev_ready", ev_ready, 1);
    @(negedge clk);
    ev_valid = 0;
    if (mv[s]) mremove(s);
    mv[s] = 1; ma[s] = a; md[s] = d;
    mpush(s);
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input bit dv, input logic [AW-1:0] da,
                           input logic [DW-1:0] dd, input int hold);
    int s = mfind(a);
    @(negedge clk);
    chk(lk_ready == 1'b1, "R8 lk_ready idle", lk_ready, 1);
    lk_valid = 1; lk_addr = a; lk_disp_valid = dv; lk_disp_addr = da; lk_disp_data = dd;
    @(negedge clk);
    lk_valid = 0;
    chk(res_valid == 1'b1, "R2 res_valid", res_valid, 1);
    chk(res_hit == (s >= 0), "R3 res_hit", res_hit, s >= 0);
    chk(!(so_valid && nl_valid), "R10 exclusive", {so_valid, nl_valid}, 0);
    chk(lk_ready == 1'b0, "R8 lk_ready blocked", lk_ready, 0);
    if (s >= 0) begin
      chk(res_idx == IW'(s), "R3 res_idx", res_idx, s);
      chk(so_valid && so_addr == ma[s], "R4 so_addr", so_addr, ma[s]);
      chk(so_data == md[s], "R4 so_data", so_data, md[s]);
    end else begin
      chk(nl_valid && nl_addr == a, "R5 nl_addr", nl_addr, a);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R2 single pulse", res_valid, 0);
      if (s >= 0) chk(so_valid && so_addr == ma[s] && so_data == md[s], "R8 so hold", so_data, md[s]);
      else        chk(nl_valid && nl_addr == a, "R8 nl hold", nl_addr, a);
    end
    so_ready = 1; nl_ready = 1;
    @(negedge clk);
    so_ready = 0; nl_ready = 0;
    chk(!so_valid && !nl_valid, "R8 drained", {so_valid, nl_valid}, 0);
    if (s >= 0) begin
      mremove(s);
      if (dv) begin
        ma[s] = da; md[s] = dd;
        mpush(s);
      end else begin
        mv[s] = 0;
      end
    end
  endtask

  // probe every address; hits are swapped back with the same line
  task automatic sweep();
    for (int a = 0; a < SPACE; a++) begin
      int s = mfind(AW'(a));
      if (s >= 0) do_lookup(AW'(a), 1'b1, ma[s], md[s], 0);
      else        do_lookup(AW'(a), 1'b0, '0, '0, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = '0; md[i] = '0; ord[i] = 0; end
    repeat (3) @(negedge clk);
    // reset state
    chk(res_valid == 0 && so_valid == 0 && nl_valid == 0, "R1 reset outputs",
        {res_valid, so_valid, nl_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(lk_ready == 1, "R8 ready after reset", lk_ready, 1);
    // R1: empty buffer misses on every address
    sweep();
    // R6: fill slots 0..3 in order
    do_insert(6'd3, 16'h1003);
    do_insert(6'd17, 16'h2017);
    do_insert(6'd40, 16'h3040);
    do_insert(6'd62, 16'h4062);
    sweep();
    // R4: swap with a new displaced line, then check old gone and new present
    do_lookup(6'd40, 1'b1, 6'd9, 16'h5009, 2);
    do_lookup(6'd40, 1'b0, '0, '0, 0);
    do_lookup(6'd9, 1'b1, 6'd9, 16'h5009, 0);
    // R4 drop: slot empties; R6 next insert refills lowest empty slot
    do_lookup(6'd17, 1'b0, '0, '0, 3);
    do_lookup(6'd17, 1'b0, '0, '0, 0);
    do_insert(6'd50, 16'h6050);
    chk(ma[1] == 6'd50, "R6 model slot", ma[1], 6'd50);
    do_lookup(6'd50, 1'b1, 6'd50, 16'h6050, 0);
    sweep();
    // R7: FIFO overwrite on a full buffer
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] victim = ma[ord[N-1]];
      do_insert(fresh(k * 11 + 20), DW'(16'h7000 + k));
      do_lookup(victim, 1'b0, '0, '0, 0); // R7 oldest gone: expect miss
    end
    sweep();
    // R9: insert and lookup offered together; insert wins
    begin
      logic [AW-1:0] na = fresh(33);
      int s = mins_slot();
      @(negedge clk);
      ev_valid = 1; ev_addr = na; ev_data = 16'hBEEF;
      lk_valid = 1; lk_addr = na; lk_disp_valid = 1; lk_disp_addr = na; lk_disp_data = 16'hBEEF;
      #1;
      chk(lk_ready == 1'b0, "R9 lookup stalled", lk_ready, 0);
      @(negedge clk);
      ev_valid = 0;
      if (mv[s]) mremove(s);
      mv[s] = 1; ma[s] = na; md[s] = 16'hBEEF; mpush(s);
      chk(res_valid == 1'b0, "R9 no result yet", res_valid, 0);
      @(negedge clk);
      lk_valid = 0;
      chk(res_valid && res_hit && res_idx == IW'(s), "R9 insert first", res_idx, s);
      so_ready = 1;
      @(negedge clk);
      so_ready = 0;
      mremove(s); mpush(s);
    end
    // mixed pseudo-random traffic
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) begin
        do_insert(fresh(int'(lfsr[7:2])), lfsr);
      end else begin
        logic [AW-1:0] a = (lfsr[1] && cnt > 0) ? ma[ord[int'(lfsr[9:8]) % cnt]] : lfsr[13:8];
        do_lookup(a, lfsr[4], fresh(int'(lfsr[15:10])), ~lfsr, int'(lfsr[3:2]));
      end
    end
    sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule